// File: doc/BRIEF.md
# Video Memory Data Port Router

This block takes byte writes from a host processor aimed at a graphics engine's video-memory data port. It keeps the running 16-bit video address. Each accepted write moves that address forward by a step of 1 or 32. The step is chosen once per frame from a control input, sampled on the frame-start strobe. The address is loaded directly through a separate load port.

Every write is sent to one of three places, decided by the address masked to 14 bits. The low region goes to tile pattern RAM. The middle region goes to a 4 KB nametable RAM, seen as four 1 KB windows that can be remapped. The top region goes to a 32-entry palette held inside the block, where some entries are mirrors of others. The pattern and nametable RAMs are outside the block, so the router drives a registered write strobe, address and data for each of them.

The block also keeps three pieces of side information. A bitmap marks each 16-byte tile of pattern RAM that has been written. A sticky flag records that a palette entry changed its value. On every write the block reports which address bits toggled, and it gives a one-cycle pulse when address bit 12 goes from 0 to 1.

Top module: `vram_port_router`

## Requirements
- R1: While rst_ni is low, and after it is released, vaddr_o, addr_xor_o, a12_rise_o, both write strobes, every palette entry, pal_changed_o and dirty_o are all zero, and the step is 1.
- R2: A write adds the current step to the full 16-bit address, wrapping modulo 2^16. The step becomes 32 if step_wide_i is high on a cycle with frame_start_i, and 1 if it is low. A step change takes effect for writes after that cycle. When addr_load_i is high, the next address is addr_load_val_i, and a write in the same cycle still uses the old address.
- R3: A write whose masked address (bits 13:0) is below 0x2000, with pat_writable_i high, gives pat_we_o high on the next cycle, with pat_addr_o equal to masked bits 12:0 and pat_data_o equal to the data.
- R4: A pattern-region write while pat_writable_i is low raises no strobe and sets no dirty bit.
- R5: An accepted pattern write sets dirty_o bit (masked address / 16). Bit k of dirty_o stands for tile k. The bit is visible on the cycle after the write.
- R6: A masked address from 0x2000 to 0x3EFF gives nt_we_o on the next cycle. nt_addr_o is {bank, address bits 9:0}, where bank is nt_bank_i[2q+1:2q] and q is address bits 11:10. nt_data_o is the data.
- R7: A masked address of 0x3F00 or above writes palette entry i, where i is address bits 4:0. When i[1:0] is 0, bit 4 of i is cleared. The stored value is data bits 5:0. Entry i appears at pal_o[6i+5:6i].
- R8: pal_changed_o goes high on the cycle after a palette write whose value differs from the entry it replaces. It stays high until cleared.
- R9: On the cycle after a write, addr_xor_o equals the old address XOR the incremented address. It holds that value until the next write.
- R10: a12_rise_o is high for exactly the cycle after a write that takes address bit 12 from 0 to 1, and is low otherwise.
- R11: clear_i empties dirty_o and lowers pal_changed_o on the next cycle. A write in the same cycle is applied after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_start_i | input | 1 | Frame start; samples step_wide_i |
| step_wide_i | input | 1 | Step select: 1 means 32, 0 means 1 |
| addr_load_i | input | 1 | Load the video address |
| addr_load_val_i | input | 16 | Address to load |
| wr_i | input | 1 | Data write strobe |
| wr_data_i | input | 8 | Write data |
| nt_bank_i | input | 8 | Four 2-bit nametable page selects |
| pat_writable_i | input | 1 | Pattern RAM accepts writes |
| clear_i | input | 1 | Clear dirty bitmap and change flag |
| vaddr_o | output | 16 | Current video address |
| addr_xor_o | output | 16 | Address bits toggled by the last write |
| a12_rise_o | output | 1 | Address bit 12 rose on the last write |
| pat_we_o | output | 1 | Pattern RAM write strobe |
| pat_addr_o | output | 13 | Pattern RAM address |
| pat_data_o | output | 8 | Pattern RAM data |
| nt_we_o | output | 1 | Nametable RAM write strobe |
| nt_addr_o | output | 12 | Nametable RAM physical address |
| nt_data_o | output | 8 | Nametable RAM data |
| pal_o | output | 192 | Palette contents, 32 entries of 6 bits |
| pal_changed_o | output | 1 | Sticky palette-change flag |
| dirty_o | output | 512 | Per-tile dirty bitmap |

## Verification
Directed runs come first. A run of single steps crosses a tile boundary and the 0x1000 line, which tests the dirty indexing and the bit-12 pulse. A run of steps of 32 across the nametable shows the quadrant-to-bank mapping and shows that the frame-start sampling changes the step. Palette writes go to mirrored indices, including writes of equal values and of values with the upper data bits set. These separate the alias rule, the 6-bit truncation and the rule that the flag rises only on a real change. Further runs cover an unmasked high address, the wrap at 0xFFFF, a load in the same cycle as a write, and read-only pattern RAM. They are followed by a long random mix of writes, loads, clears and bank changes, with every output compared against a behavioural model on every cycle.

// File: rtl/vram_router_pkg.sv
package vram_router_pkg;
  localparam int VA_W      = 16;
  localparam int MASK_W    = 14;
  localparam int PAT_W     = 13;
  localparam int TILE_LOG  = 4;
  localparam int NT_PAGE_W = 10;
  localparam int NT_QUADS  = 4;
  localparam int BANK_W    = 2;
  localparam int PAL_N     = 32;
  localparam int PAL_W     = 6;
  localparam int A12_BIT   = 12;
  localparam logic [MASK_W-1:0] NT_BASE  = 14'h2000;
  localparam logic [MASK_W-1:0] PAL_BASE = 14'h3F00;

  typedef enum logic [1:0] {RGN_PAT, RGN_NT, RGN_PAL} region_e;
endpackage

// File: rtl/vram_addr_ctr.sv
module vram_addr_ctr
  import vram_router_pkg::*;
#(
  parameter int W         = VA_W,
  parameter int WIDE_STEP = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         frame_start_i,
  input  logic         step_wide_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         wr_i,
  output logic [W-1:0] vaddr_o,
  output logic [W-1:0] xor_o,
  output logic         a12_rise_o
);
  logic [W-1:0] vaddr_q, step_q, adv;

  assign adv     = vaddr_q + step_q;
  assign vaddr_o = vaddr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vaddr_q    <= '0;
      step_q     <= W'(1);
      xor_o      <= '0;
      a12_rise_o <= 1'b0;
    end else begin
      if (frame_start_i) step_q <= step_wide_i ? W'(WIDE_STEP) : W'(1);
      a12_rise_o <= 1'b0;
      if (wr_i) begin
        xor_o      <= adv ^ vaddr_q;
        a12_rise_o <= !vaddr_q[A12_BIT] && adv[A12_BIT];
      end
      if (load_i)    vaddr_q <= load_val_i;
      else if (wr_i) vaddr_q <= adv;
    end
  end

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !load_i) |=> vaddr_q == $past(vaddr_q) + $past(step_q));
  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> vaddr_q == $past(load_val_i));
  p_xor_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(xor_o));
  p_rise_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a12_rise_o |-> xor_o[A12_BIT]);
endmodule

// File: rtl/vram_region_dec.sv
module vram_region_dec
  import vram_router_pkg::*;
(
  input  logic [MASK_W-1:0] addr_i,
  output region_e           rgn_o
);
  always_comb begin
    if (addr_i < NT_BASE)       rgn_o = RGN_PAT;
    else if (addr_i < PAL_BASE) rgn_o = RGN_NT;
    else                        rgn_o = RGN_PAL;
  end
endmodule

// File: rtl/vram_pal_store.sv
module vram_pal_store #(
  parameter int N  = 32,
  parameter int W  = 6,
  localparam int IW = $clog2(N)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clear_i,
  input  logic           we_i,
  input  logic [IW-1:0]  idx_i,
  input  logic [W-1:0]   data_i,
  output logic [N*W-1:0] pal_o,
  output logic           changed_o
);
  logic [W-1:0]  pal_q [N];
  logic [IW-1:0] idx_m;

  // entries whose low two index bits are zero share storage across halves
  always_comb begin
    idx_m = idx_i;
    if (idx_i[1:0] == 2'b00) idx_m[IW-1] = 1'b0;
  end

  for (genvar g = 0; g < N; g++) begin : g_out
    assign pal_o[g*W +: W] = pal_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) pal_q[i] <= '0;
      changed_o <= 1'b0;
    end else begin
      if (clear_i) changed_o <= 1'b0;
      if (we_i) begin
        pal_q[idx_m] <= data_i;
        if (pal_q[idx_m] != data_i) changed_o <= 1'b1;
      end
    end
  end

  p_chg_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(changed_o) |-> $past(we_i));
  p_clr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !we_i) |=> !changed_o);
  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (changed_o && !clear_i) |=> changed_o);
endmodule

// File: rtl/vram_dirty_map.sv
module vram_dirty_map #(
  parameter int TILES = 512,
  localparam int IW   = $clog2(TILES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             set_i,
  input  logic [IW-1:0]    idx_i,
  output logic [TILES-1:0] map_o
);
  logic [TILES-1:0] nxt;

  always_comb begin
    nxt = clear_i ? '0 : map_o;
    if (set_i) nxt[idx_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) map_o <= '0;
    else         map_o <= nxt;
  end

  p_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> map_o[$past(idx_i)]);
  p_grow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> $countones(map_o) <= $countones($past(map_o)) + 1);
endmodule

// File: rtl/vram_port_router.sv
module vram_port_router
  import vram_router_pkg::*;
#(
  parameter int WIDE_STEP = 32,
  localparam int TILES    = 1 << (PAT_W - TILE_LOG),
  localparam int NT_W     = BANK_W + NT_PAGE_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   frame_start_i,
  input  logic                   step_wide_i,
  input  logic                   addr_load_i,
  input  logic [VA_W-1:0]        addr_load_val_i,
  input  logic                   wr_i,
  input  logic [7:0]             wr_data_i,
  input  logic [NT_QUADS*BANK_W-1:0] nt_bank_i,
  input  logic                   pat_writable_i,
  input  logic                   clear_i,
  output logic [VA_W-1:0]        vaddr_o,
  output logic [VA_W-1:0]        addr_xor_o,
  output logic                   a12_rise_o,
  output logic                   pat_we_o,
  output logic [PAT_W-1:0]       pat_addr_o,
  output logic [7:0]             pat_data_o,
  output logic                   nt_we_o,
  output logic [NT_W-1:0]        nt_addr_o,
  output logic [7:0]             nt_data_o,
  output logic [PAL_N*PAL_W-1:0] pal_o,
  output logic                   pal_changed_o,
  output logic [TILES-1:0]       dirty_o
);
  logic [MASK_W-1:0] masked;
  region_e           rgn;
  logic              pat_go, nt_go, pal_go;
  logic [BANK_W-1:0] bank;

  vram_addr_ctr #(.W(VA_W), .WIDE_STEP(WIDE_STEP)) i_ctr (
    .clk_i, .rst_ni, .frame_start_i, .step_wide_i,
    .load_i(addr_load_i), .load_val_i(addr_load_val_i), .wr_i,
    .vaddr_o, .xor_o(addr_xor_o), .a12_rise_o
  );

  assign masked = vaddr_o[MASK_W-1:0];

  vram_region_dec i_dec (.addr_i(masked), .rgn_o(rgn));

  assign pat_go = wr_i && (rgn == RGN_PAT) && pat_writable_i;
  assign nt_go  = wr_i && (rgn == RGN_NT);
  assign pal_go = wr_i && (rgn == RGN_PAL);
  assign bank   = nt_bank_i[masked[NT_PAGE_W +: BANK_W]*BANK_W +: BANK_W];

  vram_pal_store #(.N(PAL_N), .W(PAL_W)) i_pal (
    .clk_i, .rst_ni, .clear_i, .we_i(pal_go),
    .idx_i(masked[$clog2(PAL_N)-1:0]), .data_i(wr_data_i[PAL_W-1:0]),
    .pal_o, .changed_o(pal_changed_o)
  );

  vram_dirty_map #(.TILES(TILES)) i_dirty (
    .clk_i, .rst_ni, .clear_i, .set_i(pat_go),
    .idx_i(masked[PAT_W-1:TILE_LOG]), .map_o(dirty_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pat_we_o   <= 1'b0;
      pat_addr_o <= '0;
      pat_data_o <= '0;
      nt_we_o    <= 1'b0;
      nt_addr_o  <= '0;
      nt_data_o  <= '0;
    end else begin
      pat_we_o <= pat_go;
      nt_we_o  <= nt_go;
      if (wr_i) begin
        pat_addr_o <= masked[PAT_W-1:0];
        pat_data_o <= wr_data_i;
        nt_addr_o  <= {bank, masked[NT_PAGE_W-1:0]};
        nt_data_o  <= wr_data_i;
      end
    end
  end

  p_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pat_we_o && nt_we_o));
  p_ro_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pat_we_o |-> $past(pat_writable_i) && $past(wr_i));
  p_nt_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nt_we_o |-> $past(wr_i));
endmodule

// File: tb/test_vram_port_router.sv
module test_vram_port_router;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic frame_start_i = 0, step_wide_i = 0, addr_load_i = 0, wr_i = 0;
  logic pat_writable_i = 1, clear_i = 0;
  logic [15:0] addr_load_val_i = 0;
  logic [7:0]  wr_data_i = 0, nt_bank_i = 8'b00_01_10_11;
  logic [15:0] vaddr_o, addr_xor_o;
  logic a12_rise_o, pat_we_o, nt_we_o, pal_changed_o;
  logic [12:0] pat_addr_o;
  logic [11:0] nt_addr_o;
  logic [7:0]  pat_data_o, nt_data_o;
  logic [191:0] pal_o;
  logic [511:0] dirty_o;

  always #2 clk = ~clk;

  vram_port_router i_vram_port_router (
    .clk_i(clk), .rst_ni, .frame_start_i, .step_wide_i, .addr_load_i,
    .addr_load_val_i, .wr_i, .wr_data_i, .nt_bank_i, .pat_writable_i,
    .clear_i, .vaddr_o, .addr_xor_o, .a12_rise_o, .pat_we_o, .pat_addr_o,
    .pat_data_o, .nt_we_o, .nt_addr_o, .nt_data_o, .pal_o,
    .pal_changed_o, .dirty_o
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [15:0] m_vaddr, m_step, m_xor;
  logic m_rise, m_pwe, m_nwe, m_chg;
  logic [12:0] m_paddr;
  logic [11:0] m_naddr;
  logic [7:0]  m_pdat, m_ndat;
  logic [5:0]  m_pal [32];
  logic [511:0] m_dirty;

  task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cyc=%0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  task automatic m_reset();
    m_vaddr = 0; m_step = 1; m_xor = 0; m_rise = 0; m_pwe = 0; m_nwe = 0;
    m_chg = 0; m_paddr = 0; m_naddr = 0; m_pdat = 0; m_ndat = 0; m_dirty = 0;
    for (int i = 0; i < 32; i++) m_pal[i] = 0;
  endtask

  task automatic m_step_model();
    logic [15:0] nxt;
    int ma, idx, q;
    nxt = m_vaddr + m_step;
    m_rise = 0; m_pwe = 0; m_nwe = 0;
    if (clear_i) begin m_dirty = 0; m_chg = 0; end
    if (wr_i) begin
      m_xor  = nxt ^ m_vaddr;
      m_rise = !m_vaddr[12] && nxt[12];
      ma = int'(m_vaddr) % 16384;
      m_paddr = 13'(ma); m_pdat = wr_data_i; m_ndat = wr_data_i;
      q = (ma / 1024) % 4;
      m_naddr = 12'(((nt_bank_i >> (2*q)) & 3) * 1024 + ma % 1024);
      if (ma < 'h2000) begin
        if (pat_writable_i) begin m_pwe = 1; m_dirty[ma/16] = 1'b1; end
      end else if (ma < 'h3F00) begin
        m_nwe = 1;
      end else begin
        idx = ma % 32;
        if (idx % 4 == 0) idx = idx % 16;
        if (m_pal[idx] != wr_data_i[5:0]) m_chg = 1;
        m_pal[idx] = wr_data_i[5:0];
      end
    end
    if (frame_start_i) m_step = step_wide_i ? 16'd32 : 16'd1;
    if (addr_load_i) m_vaddr = addr_load_val_i;
    else if (wr_i) m_vaddr = nxt;
  endtask

  task automatic compare();
    logic [191:0] ep;
    for (int i = 0; i < 32; i++) ep[i*6 +: 6] = m_pal[i];
    if (!rst_ni) chk("R1 reset vaddr", vaddr_o, 0);
    chk("R2 vaddr", vaddr_o, m_vaddr);
    chk("R9 addr_xor", addr_xor_o, m_xor);
    chk("R10 a12_rise", a12_rise_o, m_rise);
    chk("R3/R4 pat_we", pat_we_o, m_pwe);
    if (m_pwe) chk("R3 pat addr/data", {pat_addr_o, pat_data_o}, {m_paddr, m_pdat});
    chk("R5/R11 dirty", dirty_o, m_dirty);
    chk("R6 nt_we", nt_we_o, m_nwe);
    if (m_nwe) chk("R6 nt addr/data", {nt_addr_o, nt_data_o}, {m_naddr, m_ndat});
    chk("R7 palette", pal_o, ep);
    chk("R8/R11 pal_changed", pal_changed_o, m_chg);
  endtask

  task automatic drive();
    frame_start_i = 0; addr_load_i = 0; wr_i = 0; clear_i = 0;
    rst_ni = (cyc >= 2);
    if (cyc < 88) begin
      // directed phase
      if (cyc == 2)  begin addr_load_i = 1; addr_load_val_i = 16'h0FF0; end
      if (cyc >= 3 && cyc <= 22) begin wr_i = 1; wr_data_i = 8'(cyc); end
      if (cyc == 23) begin frame_start_i = 1; step_wide_i = 1; end
      if (cyc == 24) begin addr_load_i = 1; addr_load_val_i = 16'h2000; end
      if (cyc >= 25 && cyc <= 60) begin wr_i = 1; wr_data_i = 8'(cyc * 3); end
      if (cyc == 40) begin addr_load_i = 1; addr_load_val_i = 16'h2BE0; end
      if (cyc == 61) begin frame_start_i = 1; step_wide_i = 0; end
      if (cyc == 62) begin addr_load_i = 1; addr_load_val_i = 16'h3F0C; end
      if (cyc >= 63 && cyc <= 70) begin wr_i = 1; wr_data_i = 8'hC1 + 8'(cyc); end
      if (cyc == 71) begin addr_load_i = 1; addr_load_val_i = 16'h3F1C; end
      if (cyc == 72) begin wr_i = 1; wr_data_i = 8'hC1 + 8'd63; end
      if (cyc == 73) clear_i = 1;
      if (cyc == 74) begin addr_load_i = 1; addr_load_val_i = 16'h7F1C; end
      if (cyc == 75) begin wr_i = 1; wr_data_i = 8'h40 | (8'hC1 + 8'd63); end
      if (cyc == 76) begin wr_i = 1; wr_data_i = 8'h3F; end
      if (cyc == 77) begin clear_i = 1; pat_writable_i = 0; end
      if (cyc == 78) begin addr_load_i = 1; addr_load_val_i = 16'h0040; end
      if (cyc >= 79 && cyc <= 82) begin wr_i = 1; wr_data_i = 8'h5A; end
      if (cyc == 83) begin addr_load_i = 1; addr_load_val_i = 16'hFFFE; pat_writable_i = 1; end
      if (cyc >= 84 && cyc <= 86) begin wr_i = 1; wr_data_i = 8'(cyc); end
      if (cyc == 87) begin wr_i = 1; addr_load_i = 1; addr_load_val_i = 16'h1234; end
    end else begin
      wr_i           = ($urandom % 10) < 7;
      wr_data_i      = 8'($urandom);
      addr_load_i    = ($urandom % 20) == 0;
      addr_load_val_i = 16'($urandom);
      if ($urandom % 3 == 0) addr_load_val_i = 16'h3F00 | 16'($urandom % 32);
      frame_start_i  = ($urandom % 30) == 0;
      step_wide_i    = 1'($urandom);
      clear_i        = ($urandom % 50) == 0;
      pat_writable_i = ($urandom % 5) != 0;
      if ($urandom % 40 == 0) nt_bank_i = 8'($urandom);
    end
  endtask

  initial begin
    m_reset();
    forever begin
      @(negedge clk);
      compare();
      drive();
      if (!rst_ni) m_reset(); else m_step_model();
      cyc++;
      if (cyc == 3000) begin
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired cyc=%0d actual=running expected=done", cyc);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule